// File: doc/BRIEF.md
# Dual-Channel DAC Register Bank with Configurable Pins

This block is the digital control core of a two-channel digital-to-analog converter. Each channel keeps an input register, written by a simple register-write port, and a DAC register behind it that holds the code shown to the converter. The serial front end and all analog behaviour sit outside the block. It receives a one-cycle write strobe with an address and data, plus pulses marking each rising and falling serial clock edge.

Two general pads each take a role from a 4-bit code held in a configuration register. Depending on its role, a pad can do one of several jobs. It can strobe a level-sensitive load, or force a preset code into every register. It can lock out software shutdown, override shutdown, or select the settling speed. It can flip the outputs between the two register sets. It can also drive read-back, daisy-chain, or fixed-level data out, or act as a general input. All state changes on the rising clock edge. Pad levels are taken as already synchronous to the clock.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both output codes are zero. Shutdown, shutdown kind, fast mode, pad enables and the short-load flag are all zero. Both pad roles are 1011 (general input), so `gp_in` mirrors the pads.
- R2: The write address selects the target. Address 0 is the channel A input register and address 1 is the channel B input register. Address 2 is the role configuration: bits [3:0] for pad 0 and bits [7:4] for pad 1. Address 3 is control: bit 0 and bit 1 are software shutdown for A and B, and bit 2 and bit 3 are fast mode for A and B. While no load is active, a write to an input register leaves both output codes unchanged.
- R3: Role 0000 is load. At every clock edge where such a pad is low, each DAC register takes its input register's new value, including a write made at that same edge. Loading never clears a channel's shutdown.
- R4: Roles 0001, 0010 and 0011 are active-low presets. At each edge they force both input and both DAC registers to full scale (all ones), midscale (MSB only) or zero. When several are low, zero wins over midscale and midscale wins over full scale. Input-register writes at that edge are ignored.
- R5: Role 1110 is toggle. While the pad is low, the output codes show the input registers. While it is high, or when no pad has this role, they show the DAC registers.
- R6: Role 0100 is lockout. While the pad is low, a control write leaves the software shutdown bits unchanged but still updates the fast-mode bits.
- R7: Roles 0110 and 0111 override shutdown. While such a pad is low, both `chan_shdn` bits are 1. `shdn_kind` is 01 for role 0110, and takes priority; it is 10 for role 0111, and 00 otherwise.
- R8: Role 1111 selects settling speed. When a pad holds this role, both `fast_mode` bits equal the inverted pad level. Otherwise they follow the control-register fast bits.
- R9: Pad output roles work as follows. Role 1000 drives `rb_bit`, role 1100 drives 0, and role 1101 drives 1. Together with roles 1001 and 1010, these are the only roles that assert the pad output enable.
- R10: Role 1001 captures `dc_bit` onto the pad on a clock edge with `sclk_fall` high. Role 1010 does the same on `sclk_rise`. Otherwise the pad holds its last launched bit, which resets to 0.
- R11: Role 1011 reports the pad level on `gp_in`; every other role gives 0 there. Role 0101 is reserved: the pad is tri-stated and has no effect on any output.
- R12: A load-role pad that returns high after fewer than MIN_LOAD_CYC low edges pulses `load_short` for one cycle, starting the edge after the pad is seen high. Longer pulses do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CODE_W | Write data |
| pad_in | input | 2 | Pad levels |
| pad_out | output | 2 | Pad drive values |
| pad_oe | output | 2 | Pad output enables |
| rb_bit | input | 1 | Read-back data bit from the front end |
| dc_bit | input | 1 | Daisy-chain data bit from the front end |
| sclk_rise | input | 1 | Serial clock rising-edge pulse |
| sclk_fall | input | 1 | Serial clock falling-edge pulse |
| code_a | output | CODE_W | Channel A output code |
| code_b | output | CODE_W | Channel B output code |
| chan_shdn | output | 2 | Effective shutdown per channel |
| shdn_kind | output | 2 | Hardware shutdown kind |
| fast_mode | output | 2 | Fast settling per channel |
| gp_in | output | 2 | General-purpose input levels |
| load_short | output | 1 | Load pulse too short |

## Verification
Several rules are checked on every cycle in both channels. A preset edge leaves both registers at the preset code. A load edge leaves the DAC register equal to the input register. An edge with neither a load nor a preset leaves the DAC register unchanged. Every cycle is also checked for these: a daisy-chain launch captures the bit present at the edge, a short-load flag is always preceded by a low-then-high pad, and a locked-out control write never changes the shutdown bits. Only the bench scenarios can show the role decode itself, preset priority between two pads, the toggle view, read-back and fixed-level pad drive, settling override, and the reserved role having no effect.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  typedef enum logic [3:0] {
    ROLE_LOAD   = 4'h0, ROLE_FULL  = 4'h1, ROLE_MID    = 4'h2, ROLE_ZERO  = 4'h3,
    ROLE_LOCK   = 4'h4, ROLE_RSVD  = 4'h5, ROLE_SD_LO  = 4'h6, ROLE_SD_HI = 4'h7,
    ROLE_RDBK   = 4'h8, ROLE_DC_FL = 4'h9, ROLE_DC_RS  = 4'hA, ROLE_GPI   = 4'hB,
    ROLE_DRV0   = 4'hC, ROLE_DRV1  = 4'hD, ROLE_TOGG   = 4'hE, ROLE_SETTLE = 4'hF
  } pin_role_e;

  typedef enum logic [1:0] {PRE_NONE, PRE_FULL, PRE_MID, PRE_ZERO} preset_e;

  localparam int unsigned NROLES = 16;

  function automatic logic role_drives_pad(pin_role_e r);
    return (r == ROLE_RDBK) || (r == ROLE_DC_FL) || (r == ROLE_DC_RS) ||
           (r == ROLE_DRV0) || (r == ROLE_DRV1);
  endfunction

  // zero beats mid beats full
  function automatic preset_e pick_preset(logic full_lo, logic mid_lo, logic zero_lo);
    if (zero_lo) return PRE_ZERO;
    if (mid_lo)  return PRE_MID;
    if (full_lo) return PRE_FULL;
    return PRE_NONE;
  endfunction
endpackage

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  preset_e           preset,
  input  logic              load,
  input  logic              show_input,
  output logic [CODE_W-1:0] out_code
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [CODE_W-1:0] preset_value(preset_e p);
    case (p)
      PRE_FULL: return '1;
      PRE_MID:  return MID_CODE;
      default:  return '0;
    endcase
  endfunction

  logic [CODE_W-1:0] in_q, dac_q, in_next, dac_next, preset_code;
  logic              preset_act;

  assign preset_act  = (preset != PRE_NONE);
  assign preset_code = preset_value(preset);

  always_comb begin
    in_next  = preset_act ? preset_code : (wr_en ? wr_data : in_q);
    dac_next = preset_act ? preset_code : (load ? in_next : dac_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_next;
      dac_q <= dac_next;
    end
  end

  assign out_code = show_input ? in_q : dac_q;

  // R4
  preset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_act |=> (in_q == $past(preset_code)) && (dac_q == in_q));
  // R3
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !preset_act) |=> (dac_q == in_q));
  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !preset_act) |=> (dac_q == $past(dac_q)));
endmodule

// File: rtl/dac_pin_role.sv
module dac_pin_role
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned MIN_LOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_role_e         role,
  input  logic              pad_in,
  input  logic              rb_bit,
  input  logic              dc_bit,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic [NROLES-1:0] role_hit,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              gp_val,
  output logic              short_flag
);
  localparam int unsigned CNT_W = $clog2(MIN_LOAD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOAD_CYC);

  logic             dc_q, pad_q, launch_evt, is_load, rise_evt;
  logic [CNT_W-1:0] low_cnt;

  assign role_hit = NROLES'(1) << role;
  assign pad_oe   = role_drives_pad(role);
  assign gp_val   = (role == ROLE_GPI) && pad_in;

  assign launch_evt = ((role == ROLE_DC_FL) && sclk_fall) ||
                      ((role == ROLE_DC_RS) && sclk_rise);

  always_comb begin
    case (role)
      ROLE_RDBK:             pad_out = rb_bit;
      ROLE_DC_FL, ROLE_DC_RS: pad_out = dc_q;
      ROLE_DRV1:             pad_out = 1'b1;
      default:               pad_out = 1'b0;
    endcase
  end

  assign is_load  = (role == ROLE_LOAD);
  assign rise_evt = is_load && pad_in && !pad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q       <= 1'b0;
      pad_q      <= 1'b1;
      low_cnt    <= '0;
      short_flag <= 1'b0;
    end else begin
      if (launch_evt) dc_q <= dc_bit;
      pad_q      <= pad_in;
      short_flag <= rise_evt && (low_cnt < CNT_MAX);
      if (is_load && !pad_in) begin
        if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  // R10
  dc_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> (dc_q == $past(dc_bit)));
  // R12
  short_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_flag |-> ($past(pad_in) && !$past(pad_in, 2)));
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W       = 12,
  parameter int unsigned MIN_LOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [1:0]        pad_in,
  output logic [1:0]        pad_out,
  output logic [1:0]        pad_oe,
  input  logic              rb_bit,
  input  logic              dc_bit,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [1:0]        chan_shdn,
  output logic [1:0]        shdn_kind,
  output logic [1:0]        fast_mode,
  output logic [1:0]        gp_in,
  output logic              load_short
);
  localparam int unsigned NPINS  = 2;
  localparam int unsigned NCHAN  = 2;
  localparam logic [1:0]  A_CFG  = 2'd2;
  localparam logic [1:0]  A_CTRL = 2'd3;

  logic [4*NPINS-1:0] cfg_q;
  logic [1:0]         soft_sd_q, fast_q;
  logic [NROLES-1:0]  hit [NPINS];
  logic [NROLES-1:0]  low_any, present;
  logic [NPINS-1:0]   short_v;
  logic [CODE_W-1:0]  code [NCHAN];
  logic               load, show_input, lock_low, sd_lo, sd_hi, ctrl_wr;
  preset_e            preset;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    dac_pin_role #(.MIN_LOAD_CYC(MIN_LOAD_CYC)) u_pin (
      .clk(clk), .rst_n(rst_n), .role(pin_role_e'(cfg_q[4*p +: 4])),
      .pad_in(pad_in[p]), .rb_bit(rb_bit), .dc_bit(dc_bit),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .role_hit(hit[p]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .gp_val(gp_in[p]),
      .short_flag(short_v[p]));
  end

  always_comb begin
    low_any = '0;
    present = '0;
    for (int p = 0; p < NPINS; p++) begin
      low_any |= hit[p] & {NROLES{~pad_in[p]}};
      present |= hit[p];
    end
  end

  assign load       = low_any[ROLE_LOAD];
  assign preset     = pick_preset(low_any[ROLE_FULL], low_any[ROLE_MID], low_any[ROLE_ZERO]);
  assign show_input = low_any[ROLE_TOGG];
  assign lock_low   = low_any[ROLE_LOCK];
  assign sd_lo      = low_any[ROLE_SD_LO];
  assign sd_hi      = low_any[ROLE_SD_HI];
  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    dac_chan_reg #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_addr == 2'(c))), .wr_data(wr_data),
      .preset(preset), .load(load), .show_input(show_input),
      .out_code(code[c]));
  end

  assign code_a = code[0];
  assign code_b = code[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= {NPINS{ROLE_GPI}};
      soft_sd_q <= '0;
      fast_q    <= '0;
    end else begin
      if (wr_en && (wr_addr == A_CFG)) cfg_q <= wr_data[4*NPINS-1:0];
      if (ctrl_wr) begin
        fast_q <= wr_data[3:2];
        if (!lock_low) soft_sd_q <= wr_data[1:0];
      end
    end
  end

  assign chan_shdn  = soft_sd_q | {NCHAN{sd_lo | sd_hi}};
  assign shdn_kind  = sd_lo ? 2'b01 : (sd_hi ? 2'b10 : 2'b00);
  assign fast_mode  = present[ROLE_SETTLE] ? {NCHAN{low_any[ROLE_SETTLE]}} : fast_q;
  assign load_short = |short_v;

  // R6
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && lock_low) |=> $stable(soft_sd_q));
endmodule

// File: tb/dual_dac_ctrl_test.sv
module dual_dac_ctrl_test;
  localparam int PERIOD = 10;
  localparam int W = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [1:0] pad_in = 2'b11;
  logic rb_bit = 0, dc_bit = 0, sclk_rise = 0, sclk_fall = 0;
  logic [1:0] pad_out, pad_oe, chan_shdn, shdn_kind, fast_mode, gp_in;
  logic [W-1:0] code_a, code_b;
  logic load_short;
  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_dac_ctrl #(.CODE_W(W), .MIN_LOAD_CYC(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .rb_bit(rb_bit),
    .dc_bit(dc_bit), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .code_a(code_a), .code_b(code_b), .chan_shdn(chan_shdn), .shdn_kind(shdn_kind),
    .fast_mode(fast_mode), .gp_in(gp_in), .load_short(load_short));

  typedef struct packed {
    logic         we;
    logic [1:0]   addr;
    logic [W-1:0] data;
    logic [1:0]   pads;
    logic [W-1:0] exp_a;
    logic [W-1:0] exp_b;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 12'h0E0, 2'b11, 12'h000, 12'h000, 4'd2}, // R2 pad0 load, pad1 toggle
    '{1'b1, 2'd0, 12'h123, 2'b11, 12'h000, 12'h000, 4'd2}, // R2 write held back
    '{1'b1, 2'd1, 12'h456, 2'b11, 12'h000, 12'h000, 4'd2},
    '{1'b0, 2'd0, 12'h000, 2'b10, 12'h123, 12'h456, 4'd3}, // R3 load
    '{1'b1, 2'd0, 12'hABC, 2'b10, 12'hABC, 12'h456, 4'd3}, // R3 same-edge write
    '{1'b1, 2'd1, 12'h777, 2'b11, 12'hABC, 12'h456, 4'd2}, // R2 hold
    '{1'b0, 2'd0, 12'h000, 2'b01, 12'hABC, 12'h777, 4'd5}, // R5 show input regs
    '{1'b0, 2'd0, 12'h000, 2'b11, 12'hABC, 12'h456, 4'd5}, // R5 show DAC regs
    '{1'b1, 2'd2, 12'h031, 2'b11, 12'hABC, 12'h456, 4'd4}, // R4 pad0 full, pad1 zero
    '{1'b0, 2'd0, 12'h000, 2'b10, 12'hFFF, 12'hFFF, 4'd4}, // R4 full scale
    '{1'b0, 2'd0, 12'h000, 2'b00, 12'h000, 12'h000, 4'd4}, // R4 zero wins
    '{1'b1, 2'd0, 12'h555, 2'b10, 12'hFFF, 12'hFFF, 4'd4}, // R4 write ignored
    '{1'b1, 2'd2, 12'h021, 2'b11, 12'hFFF, 12'hFFF, 4'd4}, // R4 pad0 full, pad1 mid
    '{1'b0, 2'd0, 12'h000, 2'b00, 12'h800, 12'h800, 4'd4}, // R4 mid wins
    '{1'b1, 2'd2, 12'h0BB, 2'b11, 12'h800, 12'h800, 4'd2}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "code_a", 32'(code_a), 0);
    chk("R1", "code_b", 32'(code_b), 0);
    chk("R1", "shdn", 32'(chan_shdn), 0);
    chk("R1", "fast", 32'(fast_mode), 0);
    chk("R1", "oe", 32'(pad_oe), 0);
    chk("R1", "gp_in", 32'(gp_in), 32'h3);
    rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].we; wr_addr = VECS[i].addr; wr_data = VECS[i].data;
      pad_in = VECS[i].pads;
      tick();
      wr_en = 0;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d a", i), 32'(code_a), 32'(VECS[i].exp_a));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d b", i), 32'(code_b), 32'(VECS[i].exp_b));
    end

    // R6 lockout
    wr(2'd2, 12'h0B4);
    pad_in = 2'b10;
    wr(2'd3, 12'h00F);
    chk("R6", "shdn locked", 32'(chan_shdn), 0);
    chk("R6", "fast written", 32'(fast_mode), 32'h3);
    pad_in = 2'b11;
    wr(2'd3, 12'h003);
    chk("R6", "shdn unlocked", 32'(chan_shdn), 32'h3);
    chk("R6", "fast cleared", 32'(fast_mode), 0);

    // R3 load keeps shutdown
    wr(2'd2, 12'h0B0);
    pad_in = 2'b10; tick();
    chk("R3", "shdn kept", 32'(chan_shdn), 32'h3);
    chk("R3", "code kept", 32'(code_a), 32'h800);
    pad_in = 2'b11; tick(); tick();

    // R7 shutdown overrides
    wr(2'd3, 12'h000);
    wr(2'd2, 12'h076);
    pad_in = 2'b10; tick();
    chk("R7", "shdn 1k", 32'(chan_shdn), 32'h3);
    chk("R7", "kind 1k", 32'(shdn_kind), 32'h1);
    pad_in = 2'b01; tick();
    chk("R7", "shdn 100k", 32'(chan_shdn), 32'h3);
    chk("R7", "kind 100k", 32'(shdn_kind), 32'h2);
    pad_in = 2'b11; tick();
    chk("R7", "released", 32'({chan_shdn, shdn_kind}), 0);

    // R8 settling
    wr(2'd2, 12'h0BF);
    wr(2'd3, 12'h004);
    chk("R8", "slow", 32'(fast_mode), 0);
    pad_in = 2'b10; tick();
    chk("R8", "fast", 32'(fast_mode), 32'h3);
    pad_in = 2'b11;
    wr(2'd2, 12'h0BB);
    chk("R8", "soft bits", 32'(fast_mode), 32'h1);

    // R9 pad drive
    wr(2'd2, 12'h0C8);
    rb_bit = 1; tick();
    chk("R9", "oe", 32'(pad_oe), 32'h3);
    chk("R9", "out rb1", 32'(pad_out), 32'h1);
    rb_bit = 0; tick();
    chk("R9", "out rb0", 32'(pad_out), 32'h0);
    wr(2'd2, 12'h0D5);
    chk("R9", "oe high", 32'(pad_oe), 32'h2);
    chk("R9", "out high", 32'(pad_out[1]), 32'h1);

    // R10 daisy chain
    wr(2'd2, 12'h0A9);
    dc_bit = 1; sclk_fall = 1; tick(); sclk_fall = 0;
    chk("R10", "fall launch", 32'(pad_out), 32'h1);
    dc_bit = 0; sclk_rise = 1; tick(); sclk_rise = 0;
    chk("R10", "rise 0", 32'(pad_out), 32'h1);
    dc_bit = 1; sclk_rise = 1; tick(); sclk_rise = 0;
    chk("R10", "rise 1", 32'(pad_out), 32'h3);
    dc_bit = 0; sclk_fall = 1; tick(); sclk_fall = 0;
    chk("R10", "fall 0", 32'(pad_out), 32'h2);

    // R11 general input and reserved
    wr(2'd2, 12'h0B5);
    pad_in = 2'b10; tick();
    chk("R11", "gp_in", 32'(gp_in), 32'h2);
    chk("R11", "oe off", 32'(pad_oe), 0);
    chk("R11", "rsvd no effect", 32'({code_a, chan_shdn, fast_mode}), 32'({12'h800, 2'b00, 2'b01}));
    pad_in = 2'b01; tick();
    chk("R11", "gp_in low", 32'(gp_in), 0);

    // R12 short load pulse
    pad_in = 2'b11;
    wr(2'd2, 12'h0B0);
    pad_in = 2'b10; tick(); tick();
    pad_in = 2'b11; tick();
    chk("R12", "short flagged", 32'(load_short), 1);
    tick();
    chk("R12", "one cycle", 32'(load_short), 0);
    pad_in = 2'b10;
    for (int k = 0; k < 5; k++) tick();
    pad_in = 2'b11; tick();
    chk("R12", "long ok", 32'(load_short), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule